// File: doc/BRIEF.md
# Cross-Trigger Routing Matrix

This block collects hardware trigger events from several sources and turns them into trigger outputs through a small set of shared channels. Each trigger input has a mask that selects the channels it raises. Each trigger output has a mask that selects the channels it responds to. An output that fires is held high until software acknowledges that bit. Software can also drive the channels directly: it can hold them at a level, release them, or strike them for a single clock. An external channel vector is merged into the channel state, so a neighbouring unit can feed this one.

All configuration passes through a 32-bit register port. The port has a single-cycle write strobe and an address-decoded read that returns data in the same cycle. The port applies no back-pressure: every strobed write completes in the cycle it is presented. A key register guards the configuration. Until the exact 32-bit key value has been written there, every other write is dropped. Writing any other value to that register closes the guard again. A global enable gates all routing. Read-only status words report the live trigger inputs, the latched outputs, the external channel inputs and the resulting channel outputs.

Top module: `ct_matrix`

## Requirements
- R1: After reset the unit is locked and routing is disabled. All input and output masks are zero, the held channel mask is zero, and trig_out and chan_out are zero. The lock status word at 0xFB4 reads 0x3.
- R2: Writing 0xC5ACCE55 to 0xFB0 unlocks the unit, and writing any other value there locks it. The status word at 0xFB4 shows bit 1 = locked and bit 0 = 1 always.
- R3: While the unit is locked, a write to any address other than 0xFB0 changes no register.
- R4: Bit 0 at 0x000 is the global enable, and it reads back. While it is 0, chan_out is zero and no trigger output becomes latched.
- R5: The input mask of trigger input n lives at 0x020 + 4*n. When routing is enabled, chan_out bit c is high in the same cycle if any trig_in bit n is high and its mask has bit c set.
- R6: The output mask of trigger output m lives at 0x0A0 + 4*m. trig_out[m] becomes 1 on the clock edge after a cycle in which routing is enabled and chan_out shares a set bit with that mask. A channel outside the mask has no effect on that output.
- R7: A latched trig_out[m] stays high until bit m is written as 1 at 0x010, and it is then low after that edge. If a new set for that bit arrives in the same cycle as the acknowledge, the set wins.
- R8: Writing at 0x014 ORs the data into a held channel mask. Writing at 0x018 clears the bits set in the data. The held mask reads back at 0x014 and drives chan_out while routing is enabled.
- R9: A write at 0x01C drives the written channel bits on chan_out for exactly the one cycle after the write edge. This is enough to latch any output that has those channels in its mask.
- R10: The read-only status words are: live trig_in at 0x130, latched trig_out at 0x134, external chan_in at 0x138 and chan_out at 0x13C.
- R11: External chan_in bits are ORed into chan_out while routing is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| trig_in | input | 8 | Trigger input levels |
| chan_in | input | 4 | External channel inputs |
| trig_out | output | 8 | Latched trigger outputs |
| chan_out | output | 4 | Active channel vector |

## Verification
The assertions check on every cycle that the following hold:
- a locked write leaves the enable untouched, and the key and non-key writes move the lock state;
- a disabled unit keeps its channels quiet, and external channels reach chan_out;
- any enabled channel in an output mask latches that output, and a latched output only falls on its acknowledge bit;
- a software pulse never appears without the write that caused it.

The bench alone shows the reset values and the readback of the masks. Its full sweep of every input, channel and output pairing shows the mask decode is right. It also covers the set-over-acknowledge priority, the held-mask set and clear sequence, and the contents of each status word.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL     = 12'h000;
  localparam logic [ADDR_W-1:0] A_ACK      = 12'h010;
  localparam logic [ADDR_W-1:0] A_SWSET    = 12'h014;
  localparam logic [ADDR_W-1:0] A_SWCLR    = 12'h018;
  localparam logic [ADDR_W-1:0] A_SWPULSE  = 12'h01C;
  localparam logic [ADDR_W-1:0] A_INMASK   = 12'h020;
  localparam logic [ADDR_W-1:0] A_OUTMASK  = 12'h0A0;
  localparam logic [ADDR_W-1:0] A_ST_TIN   = 12'h130;
  localparam logic [ADDR_W-1:0] A_ST_TOUT  = 12'h134;
  localparam logic [ADDR_W-1:0] A_ST_CIN   = 12'h138;
  localparam logic [ADDR_W-1:0] A_ST_COUT  = 12'h13C;
  localparam logic [ADDR_W-1:0] A_KEY      = 12'hFB0;
  localparam logic [ADDR_W-1:0] A_KEYSTAT  = 12'hFB4;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;
endpackage

// File: rtl/ct_lock_gate.sv
module ct_lock_gate
  import ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic              wr_ok
);
  logic key_hit;
  assign key_hit = wr_en && (addr == A_KEY);

  always_ff @(posedge clk) begin
    if (rst)          locked <= 1'b1;
    else if (key_hit) locked <= (wdata != UNLOCK_KEY);
  end

  // Only writes to non-key addresses are subject to the guard
  assign wr_ok = wr_en && !locked && !key_hit;
endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned FLD_W  = (N_OUT > N_CH) ? N_OUT : N_CH
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_ok,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [FLD_W-1:0]            wfld,
  output logic                        enable,
  output logic [N_IN-1:0][N_CH-1:0]   in_mask,
  output logic [N_OUT-1:0][N_CH-1:0]  out_mask,
  output logic [N_CH-1:0]             sw_hold,
  output logic [N_CH-1:0]             sw_pulse,
  output logic [N_OUT-1:0]            ack
);
  always_ff @(posedge clk) begin
    if (rst)                              enable <= 1'b0;
    else if (wr_ok && addr == A_CTRL)     enable <= wfld[0];
  end

  for (genvar n = 0; n < N_IN; n++) begin : g_in
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(A_INMASK + 4*n);
    always_ff @(posedge clk) begin
      if (rst)                        in_mask[n] <= '0;
      else if (wr_ok && addr == MY_A) in_mask[n] <= wfld[N_CH-1:0];
    end
  end

  for (genvar m = 0; m < N_OUT; m++) begin : g_out
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(A_OUTMASK + 4*m);
    always_ff @(posedge clk) begin
      if (rst)                        out_mask[m] <= '0;
      else if (wr_ok && addr == MY_A) out_mask[m] <= wfld[N_CH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_hold  <= '0;
      sw_pulse <= '0;
    end else begin
      if (wr_ok && addr == A_SWSET)      sw_hold <= sw_hold | wfld[N_CH-1:0];
      else if (wr_ok && addr == A_SWCLR) sw_hold <= sw_hold & ~wfld[N_CH-1:0];
      sw_pulse <= (wr_ok && addr == A_SWPULSE) ? wfld[N_CH-1:0] : '0;
    end
  end

  assign ack = (wr_ok && addr == A_ACK) ? wfld[N_OUT-1:0] : '0;
endmodule

// File: rtl/ct_route.sv
module ct_route #(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned N_CH  = 4
) (
  input  logic                      enable,
  input  logic [N_IN-1:0]           trig_in,
  input  logic [N_IN-1:0][N_CH-1:0] in_mask,
  input  logic [N_CH-1:0]           chan_in,
  input  logic [N_CH-1:0]           sw_hold,
  input  logic [N_CH-1:0]           sw_pulse,
  output logic [N_CH-1:0]           chan_out
);
  logic [N_CH-1:0] from_trig;

  always_comb begin
    from_trig = '0;
    for (int n = 0; n < N_IN; n++)
      if (trig_in[n]) from_trig = from_trig | in_mask[n];
  end

  assign chan_out = enable ? (from_trig | chan_in | sw_hold | sw_pulse) : '0;
endmodule

// File: rtl/ct_out_latch.sv
module ct_out_latch #(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned N_CH  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enable,
  input  logic [N_CH-1:0]            chan,
  input  logic [N_OUT-1:0][N_CH-1:0] out_mask,
  input  logic [N_OUT-1:0]           ack,
  output logic [N_OUT-1:0]           trig_out
);
  logic [N_OUT-1:0] fire;

  for (genvar m = 0; m < N_OUT; m++) begin : g_fire
    assign fire[m] = enable && |(chan & out_mask[m]);
  end

  // A fresh set overrides an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) trig_out <= '0;
    else     trig_out <= (trig_out & ~ack) | fire;
  end
endmodule

// File: rtl/ct_matrix.sv
module ct_matrix
  import ct_pkg::*;
#(
  parameter int unsigned N_TRIG_IN  = 8,
  parameter int unsigned N_TRIG_OUT = 8,
  parameter int unsigned N_CHAN     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [N_TRIG_IN-1:0]  trig_in,
  input  logic [N_CHAN-1:0]     chan_in,
  output logic [N_TRIG_OUT-1:0] trig_out,
  output logic [N_CHAN-1:0]     chan_out
);
  localparam int unsigned FLD_W = (N_TRIG_OUT > N_CHAN) ? N_TRIG_OUT : N_CHAN;

  logic                                locked_w;
  logic                                wr_ok_w;
  logic                                enable_w;
  logic [N_TRIG_IN-1:0][N_CHAN-1:0]    in_mask_w;
  logic [N_TRIG_OUT-1:0][N_CHAN-1:0]   out_mask_w;
  logic [N_CHAN-1:0]                   sw_hold_w;
  logic [N_CHAN-1:0]                   sw_pulse_w;
  logic [N_TRIG_OUT-1:0]               ack_w;

  ct_lock_gate u_lock (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .locked (locked_w),
    .wr_ok  (wr_ok_w)
  );

  ct_regs #(
    .N_IN  (N_TRIG_IN),
    .N_OUT (N_TRIG_OUT),
    .N_CH  (N_CHAN),
    .FLD_W (FLD_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_ok    (wr_ok_w),
    .addr     (reg_addr),
    .wfld     (reg_wdata[FLD_W-1:0]),
    .enable   (enable_w),
    .in_mask  (in_mask_w),
    .out_mask (out_mask_w),
    .sw_hold  (sw_hold_w),
    .sw_pulse (sw_pulse_w),
    .ack      (ack_w)
  );

  ct_route #(
    .N_IN (N_TRIG_IN),
    .N_CH (N_CHAN)
  ) u_route (
    .enable   (enable_w),
    .trig_in  (trig_in),
    .in_mask  (in_mask_w),
    .chan_in  (chan_in),
    .sw_hold  (sw_hold_w),
    .sw_pulse (sw_pulse_w),
    .chan_out (chan_out)
  );

  ct_out_latch #(
    .N_OUT (N_TRIG_OUT),
    .N_CH  (N_CHAN)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable_w),
    .chan     (chan_out),
    .out_mask (out_mask_w),
    .ack      (ack_w),
    .trig_out (trig_out)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:    reg_rdata = DATA_W'(enable_w);
      A_SWSET:   reg_rdata = DATA_W'(sw_hold_w);
      A_ST_TIN:  reg_rdata = DATA_W'(trig_in);
      A_ST_TOUT: reg_rdata = DATA_W'(trig_out);
      A_ST_CIN:  reg_rdata = DATA_W'(chan_in);
      A_ST_COUT: reg_rdata = DATA_W'(chan_out);
      A_KEYSTAT: reg_rdata = DATA_W'({locked_w, 1'b1});
      default:   reg_rdata = '0;
    endcase
    for (int n = 0; n < N_TRIG_IN; n++)
      if (reg_addr == ADDR_W'(A_INMASK + 4*n)) reg_rdata = DATA_W'(in_mask_w[n]);
    for (int m = 0; m < N_TRIG_OUT; m++)
      if (reg_addr == ADDR_W'(A_OUTMASK + 4*m)) reg_rdata = DATA_W'(out_mask_w[m]);
  end
endmodule

// File: rtl/ct_matrix_chk.sv
module ct_matrix_chk
  import ct_pkg::*;
#(
  parameter int unsigned N_TRIG_OUT = 8,
  parameter int unsigned N_CHAN     = 4
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              reg_wr,
  input logic [ADDR_W-1:0]                 reg_addr,
  input logic [DATA_W-1:0]                 reg_wdata,
  input logic                              locked,
  input logic                              enable,
  input logic [N_CHAN-1:0]                 chan_in,
  input logic [N_CHAN-1:0]                 chan_out,
  input logic [N_CHAN-1:0]                 sw_pulse,
  input logic [N_TRIG_OUT-1:0][N_CHAN-1:0] out_mask,
  input logic [N_TRIG_OUT-1:0]             ack,
  input logic [N_TRIG_OUT-1:0]             trig_out
);
  assert_unlock_on_key_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_KEY && reg_wdata == UNLOCK_KEY) |=> !locked);

  assert_lock_on_other_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_KEY && reg_wdata != UNLOCK_KEY) |=> locked);

  assert_locked_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && locked && reg_addr == A_CTRL) |=> $stable(enable));

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (chan_out == '0));

  assert_ext_chan_merge_R11: assert property (@(posedge clk) disable iff (rst)
    enable |-> ((chan_in & ~chan_out) == '0));

  assert_pulse_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (sw_pulse != '0) |-> $past(reg_wr && !locked && reg_addr == A_SWPULSE));

  for (genvar m = 0; m < N_TRIG_OUT; m++) begin : g_out
    assert_output_sets_R6: assert property (@(posedge clk) disable iff (rst)
      (enable && |(chan_out & out_mask[m])) |=> trig_out[m]);

    assert_held_until_ack_R7: assert property (@(posedge clk) disable iff (rst)
      (trig_out[m] && !ack[m]) |=> trig_out[m]);
  end
endmodule

bind ct_matrix ct_matrix_chk #(
  .N_TRIG_OUT (N_TRIG_OUT),
  .N_CHAN     (N_CHAN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .locked    (locked_w),
  .enable    (enable_w),
  .chan_in   (chan_in),
  .chan_out  (chan_out),
  .sw_pulse  (sw_pulse_w),
  .out_mask  (out_mask_w),
  .ack       (ack_w),
  .trig_out  (trig_out)
);

// File: tb/sim_ct_matrix.sv
`timescale 1ns/1ps
module sim_ct_matrix;
  localparam int NI = 8;
  localparam int NO = 8;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NI-1:0] trig_in = '0;
  logic [NC-1:0] chan_in = '0;
  logic [NO-1:0] trig_out;
  logic [NC-1:0] chan_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ct_matrix u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .chan_in(chan_in), .trig_out(trig_out), .chan_out(chan_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 trig_out", 32'(trig_out), 0);
    check("R1 chan_out", 32'(chan_out), 0);
    rd(12'hFB4, v); check("R1 lock status", v, 32'h3);
    rd(12'h000, v); check("R1 ctrl", v, 0);
    rd(12'h020, v); check("R1 in mask", v, 0);
    rd(12'h0BC, v); check("R1 out mask", v, 0);
    rd(12'h014, v); check("R1 hold", v, 0);

    // R3: writes while locked
    wr(12'h000, 32'h1);
    rd(12'h000, v); check("R3 ctrl locked", v, 0);
    wr(12'h024, 32'hF);
    rd(12'h024, v); check("R3 in mask locked", v, 0);

    // R2: unlock with key
    wr(12'hFB0, 32'hC5ACCE55);
    rd(12'hFB4, v); check("R2 unlocked status", v, 32'h1);

    // R4: disabled blocks routing
    wr(12'h020, 32'h1);
    wr(12'h0A0, 32'h1);
    trig_in = 8'h01;
    #1 check("R4 chan quiet", 32'(chan_out), 0);
    @(negedge clk);
    check("R4 no latch", 32'(trig_out), 0);
    trig_in = '0;
    wr(12'h020, 32'h0);
    wr(12'h0A0, 32'h0);
    wr(12'h000, 32'h1);
    rd(12'h000, v); check("R4 enable readback", v, 32'h1);

    // R5 R6 R7: full sweep of input, channel, output
    for (int n = 0; n < NI; n++) begin
      for (int c = 0; c < NC; c++) begin
        for (int m = 0; m < NO; m++) begin
          wr(12'(32'h020 + 4*n), 32'(1 << c));
          wr(12'(32'h0A0 + 4*m), 32'(1 << c));
          trig_in = 8'(1 << n);
          #1 check("R5 chan from trig", 32'(chan_out), 32'(1 << c));
          @(negedge clk);
          check("R6 output latched", 32'(trig_out), 32'(1 << m));
          trig_in = '0;
          @(negedge clk);
          check("R7 held after trig drops", 32'(trig_out), 32'(1 << m));
          wr(12'h010, 32'(1 << m));
          check("R7 cleared by ack", 32'(trig_out), 0);
          wr(12'(32'h0A0 + 4*m), 32'(1 << ((c + 1) % NC)));
          trig_in = 8'(1 << n);
          @(negedge clk);
          check("R6 unmasked channel ignored", 32'(trig_out), 0);
          trig_in = '0;
          wr(12'(32'h020 + 4*n), 32'h0);
          wr(12'(32'h0A0 + 4*m), 32'h0);
        end
      end
    end

    // R7: set wins over ack
    wr(12'h020, 32'h1);
    wr(12'h0A0, 32'h1);
    trig_in = 8'h01;
    @(negedge clk);
    wr(12'h010, 32'h1);
    check("R7 set beats ack", 32'(trig_out), 32'h1);
    trig_in = '0;
    wr(12'h010, 32'h1);
    check("R7 ack after release", 32'(trig_out), 0);
    wr(12'h020, 32'h0);
    wr(12'h0A0, 32'h0);

    // R8: held channels
    wr(12'h014, 32'h5);
    rd(12'h014, v); check("R8 hold readback", v, 32'h5);
    check("R8 hold drives chan", 32'(chan_out), 32'h5);
    wr(12'h018, 32'h1);
    rd(12'h014, v); check("R8 clear readback", v, 32'h4);
    check("R8 clear drives chan", 32'(chan_out), 32'h4);
    wr(12'h018, 32'h4);
    check("R8 all cleared", 32'(chan_out), 0);

    // R9: single-cycle pulse
    wr(12'h0A8, 32'h8);
    wr(12'h01C, 32'h8);
    #1 check("R9 pulse present", 32'(chan_out), 32'h8);
    @(negedge clk);
    check("R9 pulse gone", 32'(chan_out), 0);
    check("R9 pulse latched output", 32'(trig_out), 32'h4);
    wr(12'h010, 32'h4);
    wr(12'h0A8, 32'h0);

    // R10 R11: status and external channels
    chan_in = 4'h2;
    #1 check("R11 ext chan", 32'(chan_out), 32'h2);
    rd(12'h138, v); check("R10 chan in status", v, 32'h2);
    rd(12'h13C, v); check("R10 chan out status", v, 32'h2);
    chan_in = '0;
    trig_in = 8'h81;
    rd(12'h130, v); check("R10 trig in status", v, 32'h81);
    trig_in = '0;
    wr(12'h0B0, 32'h1);
    wr(12'h014, 32'h1);
    @(negedge clk);
    rd(12'h134, v); check("R10 trig out status", v, 32'h10);
    wr(12'h018, 32'h1);
    wr(12'h010, 32'h10);

    // R2 R3: relock with wrong value
    wr(12'hFB0, 32'h0);
    rd(12'hFB4, v); check("R2 relocked status", v, 32'h3);
    wr(12'h000, 32'h0);
    rd(12'h000, v); check("R3 ctrl kept", v, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule